// File: doc/BRIEF.md
# Completer Request Descriptor Parser

This block sits behind a PCIe completer-request stream. It takes packets on a 64-bit AXI4-Stream slave port and splits each one into two parts. Every packet starts with a fixed four-DW descriptor, which is followed by payload DWs when the request carries data. The descriptor always fills the first two beats. The block collects the request fields from those two beats into one registered header record, which leaves on its own valid/ready port. Any payload DWs are passed on through a registered output stream that carries one keep bit per DW.

The two byte-enable nibbles do not travel inside the descriptor. They arrive on the sideband user bits and are sampled once, on the first beat of the packet. The descriptor always gives the address as a full 64-bit value, whatever addressing the link used. The two lowest address bits hold a translation code, so they are cleared on output. Backpressure works on both outputs. A header record that has not been consumed stops the next descriptor from completing, and a stalled payload register stops the payload beats.

Top module: `creq_desc_parser`

## Requirements
- R1: `hdr_addr` is {DW1, DW0} of the first beat, where DW0 is data bits [31:0] and DW1 is data bits [63:32]. Bits [1:0] of `hdr_addr` are always 0.
- R2: `hdr_first_be` is user bits [3:0] and `hdr_last_be` is user bits [7:4], both taken from the first beat only. User bits on any other beat have no effect on them.
- R3: From DW2 (second beat, data bits [31:0]): `hdr_dw_len` is DW2[10:0], `hdr_req_type` is DW2[14:11] and `hdr_req_id` is DW2[31:16]. A length of 1024 appears as 11'd1024.
- R4: From DW3 (second beat, data bits [63:32]): `hdr_tag` is DW3[7:0], `hdr_tc` is DW3[27:25] and `hdr_attr` is DW3[30:28]. All other DW3 bits are ignored.
- R5: `hdr_valid` rises in the cycle after the second beat is accepted. While `hdr_ready` is low, `hdr_valid` and every header field stay unchanged.
- R6: While a header record is pending and `hdr_ready` is low, the first beat of the next packet is still accepted, but its second beat is refused (`req_tready` low).
- R7: Every beat after the second is a payload beat. It shows up on `pl_tdata` without change in the cycle after it is accepted, and its last flag is carried on `pl_tlast`.
- R8: `pl_tkeep[i]` is 1 exactly when the payload DWs still owed, counted from `hdr_dw_len`, are more than i. Each payload beat consumes the DWs it keeps.
- R9: A beat accepted with `req_tlast` high sends the parser back to expecting a descriptor's first beat. A packet cut short this way produces no header record.
- R10: While `pl_tvalid` is high and `pl_tready` is low, `req_tready` is low during payload and `pl_tdata` stays unchanged. No payload beat is lost or repeated.
- R11: After reset `hdr_valid` and `pl_tvalid` are 0 and `req_tready` is 1.
- R12: When `hdr_ready` consumes a record in the same cycle that a new second beat is accepted, the new record follows with no empty cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_tdata | input | 64 | Incoming beat, two little-endian DWs |
| req_tuser | input | 8 | Sideband; byte enables on the first beat |
| req_tlast | input | 1 | Last beat of packet |
| req_tvalid | input | 1 | Incoming beat valid |
| req_tready | output | 1 | Parser accepts beat |
| hdr_valid | output | 1 | Header record valid |
| hdr_ready | input | 1 | Header record consumed |
| hdr_addr | output | 64 | Request address, bits [1:0] zero |
| hdr_dw_len | output | 11 | Length in DWs |
| hdr_req_type | output | 4 | Request type code |
| hdr_req_id | output | 16 | Requester ID |
| hdr_tag | output | 8 | Request tag |
| hdr_tc | output | 3 | Traffic class |
| hdr_attr | output | 3 | Attributes |
| hdr_first_be | output | 4 | First-DW byte enables |
| hdr_last_be | output | 4 | Last-DW byte enables |
| pl_tdata | output | 64 | Payload beat |
| pl_tkeep | output | 2 | One keep bit per DW |
| pl_tlast | output | 1 | Last payload beat |
| pl_tvalid | output | 1 | Payload beat valid |
| pl_tready | input | 1 | Payload beat consumed |

## Verification
Two things can happen in the same clock edge. One is the hand-off of a pending header record, and the other is the commit of the next descriptor's second beat. The bench holds `hdr_ready` low and lets a second packet reach its second beat, where it must stall. It then raises `hdr_ready` for one cycle and expects the second record on the outputs at the next sample point, with no gap. A similar overlap happens on the payload side. A stalled payload register is drained in the same edge that accepts the next payload beat, and the bench checks that order and content are kept.

// File: rtl/creq_pkg.sv
package creq_pkg;

  localparam int unsigned DW_BITS  = 32;
  localparam int unsigned LEN_BITS = 11;
  localparam int unsigned BE_BITS  = 4;

  typedef enum logic [1:0] {
    BT_ADDR = 2'd0,
    BT_ID   = 2'd1,
    BT_DATA = 2'd2
  } beat_e;

  typedef struct packed {
    logic [63:0]         addr;
    logic [LEN_BITS-1:0] dw_len;
    logic [3:0]          req_type;
    logic [15:0]         req_id;
    logic [7:0]          tag;
    logic [2:0]          tc;
    logic [2:0]          attr;
    logic [BE_BITS-1:0]  first_be;
    logic [BE_BITS-1:0]  last_be;
  } hdr_rec_t;

endpackage

// File: rtl/creq_beat_tracker.sv
module creq_beat_tracker
  import creq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  beat_fire,
  input  logic  beat_last,
  output beat_e beat_q
);

  beat_e beat_n;

  always_comb begin
    beat_n = beat_q;
    if (beat_fire) begin
      if (beat_last) begin
        beat_n = BT_ADDR;
      end else begin
        case (beat_q)
          BT_ADDR: beat_n = BT_ID;
          BT_ID:   beat_n = BT_DATA;
          default: beat_n = BT_DATA;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= BT_ADDR;
    else        beat_q <= beat_n;
  end

  // R9: a closing beat re-arms the descriptor start
  p_last_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && beat_last) |=> (beat_q == BT_ADDR));

  // R7: payload state is only reached through the identity beat
  p_data_after_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_q == BT_ADDR) |=> (beat_q != BT_DATA));

endmodule

// File: rtl/creq_hdr_stage.sv
module creq_hdr_stage
  import creq_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned USER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_fire,
  input  logic              id_fire,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [USER_W-1:0] beat_user,
  input  logic              hdr_ready,
  output logic              hdr_valid,
  output hdr_rec_t          hdr_q,
  output logic              slot_free
);

  localparam int unsigned LO = 0;
  localparam int unsigned HI = DW_BITS;

  logic [63:0]        st_addr_q,  st_addr_n;
  logic [BE_BITS-1:0] st_fbe_q,   st_fbe_n;
  logic [BE_BITS-1:0] st_lbe_q,   st_lbe_n;
  hdr_rec_t           hdr_n;
  logic               valid_n;
  logic [DW_BITS-1:0] dw_lo, dw_hi;

  assign dw_lo     = beat_data[LO +: DW_BITS];
  assign dw_hi     = beat_data[HI +: DW_BITS];
  assign slot_free = !hdr_valid || hdr_ready;

  // staging of the first beat
  always_comb begin
    st_addr_n = st_addr_q;
    st_fbe_n  = st_fbe_q;
    st_lbe_n  = st_lbe_q;
    if (addr_fire) begin
      st_addr_n = {dw_hi, dw_lo[DW_BITS-1:2], 2'b00};
      st_fbe_n  = beat_user[BE_BITS-1:0];
      st_lbe_n  = beat_user[2*BE_BITS-1:BE_BITS];
    end
  end

  // record assembly on the second beat
  always_comb begin
    hdr_n   = hdr_q;
    valid_n = hdr_valid;
    if (hdr_ready) valid_n = 1'b0;
    if (id_fire) begin
      hdr_n.addr     = st_addr_q;
      hdr_n.first_be = st_fbe_q;
      hdr_n.last_be  = st_lbe_q;
      hdr_n.dw_len   = dw_lo[LEN_BITS-1:0];
      hdr_n.req_type = dw_lo[14:11];
      hdr_n.req_id   = dw_lo[31:16];
      hdr_n.tag      = dw_hi[7:0];
      hdr_n.tc       = dw_hi[27:25];
      hdr_n.attr     = dw_hi[30:28];
      valid_n        = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_addr_q <= '0;
      st_fbe_q  <= '0;
      st_lbe_q  <= '0;
    end else if (addr_fire) begin
      st_addr_q <= st_addr_n;
      st_fbe_q  <= st_fbe_n;
      st_lbe_q  <= st_lbe_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
    end else if (id_fire) begin
      hdr_q <= hdr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_valid <= 1'b0;
    else        hdr_valid <= valid_n;
  end

  // R5: a pending record is held untouched
  p_hdr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_ready) |=> (hdr_valid && $stable(hdr_q)));

  // R6: no commit over an unconsumed record
  p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hdr_ready) |-> !id_fire);

  // R5: record appears right after the second beat
  p_hdr_after_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
    id_fire |=> hdr_valid);

endmodule

// File: rtl/creq_pay_stage.sv
module creq_pay_stage
  import creq_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 len_load,
  input  logic [LEN_BITS-1:0]  len_in,
  input  logic                 pay_fire,
  input  logic [DATA_W-1:0]    beat_data,
  input  logic                 beat_last,
  input  logic                 pl_tready,
  output logic                 pl_tvalid,
  output logic [DATA_W-1:0]    pl_tdata,
  output logic [DATA_W/DW_BITS-1:0] pl_tkeep,
  output logic                 pl_tlast,
  output logic                 slot_free
);

  localparam int unsigned NDW = DATA_W / DW_BITS;

  logic [LEN_BITS-1:0] rem_q, rem_n;
  logic [NDW-1:0]      keep_now;
  logic [LEN_BITS-1:0] keep_cnt;
  logic                valid_n;

  assign slot_free = !pl_tvalid || pl_tready;

  for (genvar g = 0; g < NDW; g++) begin : g_keep
    assign keep_now[g] = (rem_q > LEN_BITS'(g));
  end

  always_comb begin
    keep_cnt = '0;
    for (int i = 0; i < NDW; i++) begin
      keep_cnt = keep_cnt + LEN_BITS'(keep_now[i]);
    end
  end

  always_comb begin
    rem_n = rem_q;
    if (len_load)      rem_n = len_in;
    else if (pay_fire) rem_n = rem_q - keep_cnt;
  end

  always_comb begin
    valid_n = pl_tvalid;
    if (pl_tready) valid_n = 1'b0;
    if (pay_fire)  valid_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else if (len_load || pay_fire) rem_q <= rem_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_tdata <= '0;
      pl_tkeep <= '0;
      pl_tlast <= 1'b0;
    end else if (pay_fire) begin
      pl_tdata <= beat_data;
      pl_tkeep <= keep_now;
      pl_tlast <= beat_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pl_tvalid <= 1'b0;
    else        pl_tvalid <= valid_n;
  end

  // R10: a stalled payload beat stays put
  p_pl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_tvalid && !pl_tready) |=> (pl_tvalid && $stable(pl_tdata) && $stable(pl_tkeep)));

  // R10: no beat accepted over a stalled one
  p_no_clobber_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_tvalid && !pl_tready) |-> !pay_fire);

  // R8: keep is a contiguous run from lane 0
  p_keep_thermo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pl_tvalid |-> (pl_tkeep == NDW'((1 << $countones(pl_tkeep)) - 1)));

endmodule

// File: rtl/creq_desc_parser.sv
module creq_desc_parser
  import creq_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned USER_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DATA_W-1:0]         req_tdata,
  input  logic [USER_W-1:0]         req_tuser,
  input  logic                      req_tlast,
  input  logic                      req_tvalid,
  output logic                      req_tready,
  output logic                      hdr_valid,
  input  logic                      hdr_ready,
  output logic [63:0]               hdr_addr,
  output logic [LEN_BITS-1:0]       hdr_dw_len,
  output logic [3:0]                hdr_req_type,
  output logic [15:0]               hdr_req_id,
  output logic [7:0]                hdr_tag,
  output logic [2:0]                hdr_tc,
  output logic [2:0]                hdr_attr,
  output logic [BE_BITS-1:0]        hdr_first_be,
  output logic [BE_BITS-1:0]        hdr_last_be,
  output logic [DATA_W-1:0]         pl_tdata,
  output logic [DATA_W/DW_BITS-1:0] pl_tkeep,
  output logic                      pl_tlast,
  output logic                      pl_tvalid,
  input  logic                      pl_tready
);

  beat_e    beat_q;
  logic     fire;
  logic     addr_fire, id_fire, pay_fire;
  logic     hdr_free, pay_free;
  hdr_rec_t hdr_q;

  always_comb begin
    case (beat_q)
      BT_ADDR: req_tready = 1'b1;
      BT_ID:   req_tready = hdr_free;
      default: req_tready = pay_free;
    endcase
  end

  assign fire      = req_tvalid && req_tready;
  assign addr_fire = fire && (beat_q == BT_ADDR);
  assign id_fire   = fire && (beat_q == BT_ID);
  assign pay_fire  = fire && (beat_q == BT_DATA);

  creq_beat_tracker i_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_fire (fire),
    .beat_last (req_tlast),
    .beat_q    (beat_q)
  );

  creq_hdr_stage #(
    .DATA_W (DATA_W),
    .USER_W (USER_W)
  ) i_hdr (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_fire (addr_fire),
    .id_fire   (id_fire),
    .beat_data (req_tdata),
    .beat_user (req_tuser),
    .hdr_ready (hdr_ready),
    .hdr_valid (hdr_valid),
    .hdr_q     (hdr_q),
    .slot_free (hdr_free)
  );

  creq_pay_stage #(
    .DATA_W (DATA_W)
  ) i_pay (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_load  (id_fire),
    .len_in    (req_tdata[LEN_BITS-1:0]),
    .pay_fire  (pay_fire),
    .beat_data (req_tdata),
    .beat_last (req_tlast),
    .pl_tready (pl_tready),
    .pl_tvalid (pl_tvalid),
    .pl_tdata  (pl_tdata),
    .pl_tkeep  (pl_tkeep),
    .pl_tlast  (pl_tlast),
    .slot_free (pay_free)
  );

  assign hdr_addr     = hdr_q.addr;
  assign hdr_dw_len   = hdr_q.dw_len;
  assign hdr_req_type = hdr_q.req_type;
  assign hdr_req_id   = hdr_q.req_id;
  assign hdr_tag      = hdr_q.tag;
  assign hdr_tc       = hdr_q.tc;
  assign hdr_attr     = hdr_q.attr;
  assign hdr_first_be = hdr_q.first_be;
  assign hdr_last_be  = hdr_q.last_be;

  // R12: a consumed record refilled in the same edge stays valid
  p_refill_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && id_fire) |=> hdr_valid);

  // R7: payload only moves outside descriptor beats
  p_pay_only_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_q != BT_DATA) |=> !$rose(pl_tvalid) || $past(beat_q) == BT_DATA || $past(pl_tvalid));

endmodule

// File: tb/test_creq_desc_parser.sv
module test_creq_desc_parser;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] req_tdata;
  logic [7:0]  req_tuser;
  logic        req_tlast, req_tvalid, req_tready;
  logic        hdr_valid, hdr_ready;
  logic [63:0] hdr_addr;
  logic [10:0] hdr_dw_len;
  logic [3:0]  hdr_req_type;
  logic [15:0] hdr_req_id;
  logic [7:0]  hdr_tag;
  logic [2:0]  hdr_tc, hdr_attr;
  logic [3:0]  hdr_first_be, hdr_last_be;
  logic [63:0] pl_tdata;
  logic [1:0]  pl_tkeep;
  logic        pl_tlast, pl_tvalid, pl_tready;

  int n_chk = 0;
  int n_fail = 0;

  logic [63:0] mon_d [0:599];
  logic [1:0]  mon_k [0:599];
  logic        mon_l [0:599];
  int          mon_n = 0;

  always #4 clk = ~clk;

  creq_desc_parser i_creq_desc_parser (
    .clk(clk), .rst_n(rst_n),
    .req_tdata(req_tdata), .req_tuser(req_tuser), .req_tlast(req_tlast),
    .req_tvalid(req_tvalid), .req_tready(req_tready),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_addr(hdr_addr), .hdr_dw_len(hdr_dw_len), .hdr_req_type(hdr_req_type),
    .hdr_req_id(hdr_req_id), .hdr_tag(hdr_tag), .hdr_tc(hdr_tc), .hdr_attr(hdr_attr),
    .hdr_first_be(hdr_first_be), .hdr_last_be(hdr_last_be),
    .pl_tdata(pl_tdata), .pl_tkeep(pl_tkeep), .pl_tlast(pl_tlast),
    .pl_tvalid(pl_tvalid), .pl_tready(pl_tready)
  );

  always @(posedge clk) begin
    if (rst_n && pl_tvalid && pl_tready && mon_n < 600) begin
      mon_d[mon_n] <= pl_tdata;
      mon_k[mon_n] <= pl_tkeep;
      mon_l[mon_n] <= pl_tlast;
      mon_n <= mon_n + 1;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] id_beat(input logic [10:0] len, input logic [3:0] typ,
      input logic [15:0] rid, input logic [7:0] tag, input logic [2:0] tc, input logic [2:0] attr);
    logic [31:0] dw2, dw3;
    dw2 = {rid, 1'b0, typ, len};
    dw3 = {1'b1, attr, tc, 17'h15A5A, tag};
    return {dw3, dw2};
  endfunction

  task automatic send_beat(input logic [63:0] d, input logic [7:0] u, input logic l);
    req_tdata = d; req_tuser = u; req_tlast = l; req_tvalid = 1'b1;
    #1;
    while (!req_tready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    req_tvalid = 1'b0; req_tlast = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 hdr_valid", 64'(hdr_valid), 64'd0);
    check("R11 pl_tvalid", 64'(pl_tvalid), 64'd0);
    check("R11 req_tready", 64'(req_tready), 64'd1);
  endtask

  task automatic t_read_fields();
    hdr_ready = 1'b0;
    send_beat(64'h89AB_CDEF_0123_4567, 8'hA5, 1'b0);
    check("R5 no record before second beat", 64'(hdr_valid), 64'd0);
    send_beat(id_beat(11'd1024, 4'h0, 16'hBEEF, 8'h5C, 3'd5, 3'd6), 8'h3C, 1'b1);
    idle();
    check("R5 valid after second beat", 64'(hdr_valid), 64'd1);
    check("R1 address", hdr_addr, 64'h89AB_CDEF_0123_4564);
    check("R2 first_be", 64'(hdr_first_be), 64'h5);
    check("R2 last_be", 64'(hdr_last_be), 64'hA);
    check("R3 dw_len 1024", 64'(hdr_dw_len), 64'd1024);
    check("R3 req_type", 64'(hdr_req_type), 64'h0);
    check("R3 req_id", 64'(hdr_req_id), 64'hBEEF);
    check("R4 tag", 64'(hdr_tag), 64'h5C);
    check("R4 tc", 64'(hdr_tc), 64'd5);
    check("R4 attr", 64'(hdr_attr), 64'd6);
    repeat (3) @(negedge clk);
    check("R5 held valid", 64'(hdr_valid), 64'd1);
    check("R5 held tag", 64'(hdr_tag), 64'h5C);
    hdr_ready = 1'b1;
    @(negedge clk);
    hdr_ready = 1'b0;
    check("R5 consumed", 64'(hdr_valid), 64'd0);
  endtask

  task automatic t_refill_same_cycle();
    hdr_ready = 1'b0;
    send_beat(64'h0000_0001_0000_1000, 8'h11, 1'b0);
    send_beat(id_beat(11'd1, 4'h1, 16'h0101, 8'h01, 3'd0, 3'd0), 8'h00, 1'b1);
    send_beat(64'h0000_0002_0000_2003, 8'h22, 1'b0);
    check("R6 first beat accepted while full", 64'(hdr_tag), 64'h01);
    req_tdata = id_beat(11'd2, 4'h1, 16'h0202, 8'h02, 3'd1, 3'd2);
    req_tuser = 8'hFF; req_tlast = 1'b1;
    #1;
    check("R6 second beat refused", 64'(req_tready), 64'd0);
    @(negedge clk);
    check("R6 still refused", 64'(req_tready), 64'd0);
    hdr_ready = 1'b1;
    #1;
    check("R12 ready with consume", 64'(req_tready), 64'd1);
    @(negedge clk);
    idle();
    hdr_ready = 1'b0;
    check("R12 no bubble valid", 64'(hdr_valid), 64'd1);
    check("R12 new tag", 64'(hdr_tag), 64'h02);
    check("R12 new address", hdr_addr, 64'h0000_0002_0000_2000);
    check("R2 be from first beat only", 64'({hdr_last_be, hdr_first_be}), 64'h22);
    hdr_ready = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_payload_stall();
    logic [63:0] a, b;
    a = 64'h1111_2222_3333_4444;
    b = 64'h5555_6666_7777_8888;
    hdr_ready = 1'b1; pl_tready = 1'b0;
    mon_n = 0;
    send_beat(64'h0, 8'hFF, 1'b0);
    send_beat(id_beat(11'd4, 4'h1, 16'h1, 8'h10, 3'd0, 3'd0), 8'h0, 1'b0);
    send_beat(a, 8'h0, 1'b0);
    check("R7 payload one cycle later", 64'(pl_tvalid), 64'd1);
    check("R7 payload data", pl_tdata, a);
    check("R8 keep full", 64'(pl_tkeep), 64'h3);
    req_tdata = b; req_tlast = 1'b1;
    #1;
    check("R10 refused while stalled", 64'(req_tready), 64'd0);
    repeat (3) @(negedge clk);
    check("R10 data held", pl_tdata, a);
    pl_tready = 1'b1;
    send_beat(b, 8'h0, 1'b1);
    idle();
    @(negedge clk);
    check("R10 beat count", 64'(mon_n), 64'd2);
    check("R10 first beat", mon_d[0], a);
    check("R7 second beat", mon_d[1], b);
    check("R7 last flag", 64'({mon_l[1], mon_l[0]}), 64'b10);
  endtask

  task automatic t_keep_odd();
    hdr_ready = 1'b1; pl_tready = 1'b1;
    mon_n = 0;
    send_beat(64'h0, 8'h0F, 1'b0);
    send_beat(id_beat(11'd5, 4'h1, 16'h2, 8'h20, 3'd0, 3'd0), 8'h0, 1'b0);
    for (int i = 0; i < 3; i++) send_beat(64'(i + 100), 8'h0, i == 2);
    idle();
    @(negedge clk);
    check("R8 odd beats", 64'(mon_n), 64'd3);
    check("R8 keep beat0", 64'(mon_k[0]), 64'h3);
    check("R8 keep beat1", 64'(mon_k[1]), 64'h3);
    check("R8 keep tail", 64'(mon_k[2]), 64'h1);
  endtask

  task automatic t_keep_max();
    int dws;
    int bad;
    hdr_ready = 1'b1; pl_tready = 1'b1;
    mon_n = 0;
    send_beat(64'h0, 8'hFF, 1'b0);
    send_beat(id_beat(11'd1024, 4'h1, 16'h3, 8'h30, 3'd0, 3'd0), 8'h0, 1'b0);
    for (int i = 0; i < 512; i++) send_beat(64'(i), 8'h0, i == 511);
    idle();
    @(negedge clk);
    dws = 0; bad = 0;
    for (int i = 0; i < 512; i++) begin
      dws += int'(mon_k[i][0]) + int'(mon_k[i][1]);
      if (mon_d[i] != 64'(i)) bad++;
    end
    check("R8 1024 DWs kept", 64'(dws), 64'd1024);
    check("R7 1024 data order", 64'(bad), 64'd0);
    check("R7 tail last", 64'(mon_l[511]), 64'd1);
  endtask

  task automatic t_abort();
    hdr_ready = 1'b0; pl_tready = 1'b1;
    send_beat(64'hDEAD_DEAD_DEAD_DEAD, 8'hEE, 1'b1);
    idle();
    @(negedge clk);
    check("R9 no record from cut packet", 64'(hdr_valid), 64'd0);
    send_beat(64'h0000_0000_0000_4008, 8'h81, 1'b0);
    send_beat(id_beat(11'd1, 4'h0, 16'h7, 8'h77, 3'd0, 3'd0), 8'h0, 1'b1);
    idle();
    check("R9 re-armed address", hdr_addr, 64'h0000_0000_0000_4008);
    check("R9 re-armed tag", 64'(hdr_tag), 64'h77);
    hdr_ready = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_tdata = '0; req_tuser = '0; req_tlast = 1'b0; req_tvalid = 1'b0;
    hdr_ready = 1'b0; pl_tready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_fields();
    t_refill_same_cycle();
    t_payload_stall();
    t_keep_odd();
    t_keep_max();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule